// File: doc/BRIEF.md
# Indirect MMD Register Access Bridge

This block lets a host on a plain 32-bit CSR bus reach a 16-bit register space split into as many as 32 management devices (MMDs), each with a 16-bit register address. The host sees two CSR words: a command word and a data word. Writing the command word with its busy bit set launches exactly one read or one write on a back-end register port. The hardware clears the busy bit when that access completes.

For a write, the host first loads the 16-bit data word. It then writes the command word with busy and the write flag set. For a read, it writes the command word with busy set and the write flag clear. It polls until busy reads 0 and then reads the result from the data word. The back end is an internal register file that answers each request through a req/ack handshake after a configurable number of cycles. Only a small corner of the MMD/address space is built into that storage. Locations outside it read as zero and drop writes.

Top module: `mmd_csr_bridge`

## Requirements
- R1: After reset the command word and the data word both read 0, and every back-end register reads 0.
- R2: The command word is at CSR offset 0x720. Bit 31 is busy, bit 30 is the write flag (1 = write, 0 = read), bits 20:16 are the MMD number and bits 15:0 are the register address. Bits 29:21 read 0. A command write with bit 31 clear only stores the fields and starts nothing.
- R3: The data word is at CSR offset 0x724. Only bits 15:0 are stored. Bits 31:16 read 0.
- R4: A command write with bits 31 and 30 set stores the current data word into the addressed register. While the request waits for ack, the MMD, address, write flag and write data stay stable, and the data word keeps its value.
- R5: A command write with bit 31 set and bit 30 clear loads the addressed register's value into the data word, and that value is readable once busy reads 0.
- R6: Busy reads 1 for exactly LAT clock cycles after the clock edge that captures the launching command write, and then reads 0.
- R7: A command write that arrives while busy is 1 is ignored. It neither changes the command fields nor starts or alters an access.
- R8: A data-word write that arrives while busy is 1 is ignored.
- R9: Only MMD numbers below 2^MMD_IMPL_W and addresses below 2^REG_IMPL_W are backed by storage. A write elsewhere is dropped without aliasing onto a backed register, and a read elsewhere returns 0.
- R10: Writes to any other CSR offset have no effect, and any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | CSR_AW | CSR byte offset for both reads and writes |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational from csr_addr |

## Verification
The assertions assume that the host holds csr_we low except on single-cycle write strobes, and that reset is held for at least one clock edge before traffic. The back-end checks also rely on the back end raising ack only while req is high. The bench drives every CSR access at the falling edge as a one-cycle strobe, so each write is captured at exactly one rising edge. It deliberately issues command and data writes while busy is high, so that the hold and ignore properties are exercised rather than left vacuous.

// File: rtl/mmd_bridge_pkg.sv
package mmd_bridge_pkg;
   // CSR map (byte offsets)
   localparam int unsigned CMD_OFS  = 32'h720;
   localparam int unsigned DATA_OFS = 32'h724;

   // command word layout
   localparam int BUSY_BIT  = 31;
   localparam int WR_BIT    = 30;
   localparam int MMD_LSB   = 16;
   localparam int MMD_W     = 5;
   localparam int REG_AW    = 16;
   localparam int DW        = 16;

   typedef struct packed {
      logic              wr;
      logic [MMD_W-1:0]  mmd;
      logic [REG_AW-1:0] addr;
   } mmd_cmd_t;
endpackage

// File: rtl/mmd_cmd_regs.sv
module mmd_cmd_regs
   import mmd_bridge_pkg::*;
#(
   parameter int CSR_AW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [CSR_AW-1:0] csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic              be_ack,
   input  logic [DW-1:0]     be_rdata,
   output logic              busy,
   output mmd_cmd_t          cmd,
   output logic [DW-1:0]     data_q
);
   localparam logic [CSR_AW-1:0] CMD_A  = CSR_AW'(CMD_OFS);
   localparam logic [CSR_AW-1:0] DATA_A = CSR_AW'(DATA_OFS);

   if (CSR_AW < 12) begin : g_bad_aw
      $error("CSR_AW too narrow for the command and data offsets");
   end

   logic sel_cmd, sel_data;
   assign sel_cmd  = csr_we && (csr_addr == CMD_A);
   assign sel_data = csr_we && (csr_addr == DATA_A);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cmd    <= '0;
         data_q <= '0;
      end else if (busy) begin
         if (be_ack) begin
            busy <= 1'b0;
            if (!cmd.wr) data_q <= be_rdata;
         end
      end else begin
         if (sel_cmd) begin
            busy     <= csr_wdata[BUSY_BIT];
            cmd.wr   <= csr_wdata[WR_BIT];
            cmd.mmd  <= csr_wdata[MMD_LSB +: MMD_W];
            cmd.addr <= csr_wdata[REG_AW-1:0];
         end
         if (sel_data) data_q <= csr_wdata[DW-1:0];
      end
   end

   always_comb begin
      csr_rdata = '0;
      if (csr_addr == CMD_A) begin
         csr_rdata[BUSY_BIT]            = busy;
         csr_rdata[WR_BIT]              = cmd.wr;
         csr_rdata[MMD_LSB +: MMD_W]    = cmd.mmd;
         csr_rdata[REG_AW-1:0]          = cmd.addr;
      end else if (csr_addr == DATA_A) begin
         csr_rdata[DW-1:0]              = data_q;
      end
   end

   // R4
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !be_ack) |=> (busy && $stable(cmd) && $stable(data_q)));

   // R6
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(be_ack));

   // R7
   cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sel_cmd) |=> $stable(cmd));

   // R8
   data_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sel_data && !be_ack) |=> $stable(data_q));
endmodule

// File: rtl/mmd_regfile_port.sv
module mmd_regfile_port
   import mmd_bridge_pkg::*;
#(
   parameter int LAT        = 4,
   parameter int MMD_IMPL_W = 2,
   parameter int REG_IMPL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  mmd_cmd_t          cmd,
   input  logic [DW-1:0]     wdata,
   output logic              ack,
   output logic [DW-1:0]     rdata
);
   localparam int IDX_W = MMD_IMPL_W + REG_IMPL_W;
   localparam int DEPTH = 1 << IDX_W;

   if (LAT < 1) begin : g_bad_lat
      $error("LAT must be at least 1");
   end
   if (MMD_IMPL_W < 1 || MMD_IMPL_W > MMD_W) begin : g_bad_mmd
      $error("MMD_IMPL_W out of range");
   end
   if (REG_IMPL_W < 1 || REG_IMPL_W > 10) begin : g_bad_reg
      $error("REG_IMPL_W out of range");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [IDX_W-1:0] idx;
   logic             hit;

   assign idx = {cmd.mmd[MMD_IMPL_W-1:0], cmd.addr[REG_IMPL_W-1:0]};
   assign hit = ((cmd.mmd >> MMD_IMPL_W) == '0) && ((cmd.addr >> REG_IMPL_W) == '0);
   assign rdata = hit ? mem[idx] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (req && ack && cmd.wr && hit) begin
         mem[idx] <= wdata;
      end
   end

   if (LAT == 1) begin : g_lat_one
      assign ack = req;
   end else begin : g_lat_cnt
      localparam int CW = $clog2(LAT);
      logic [CW-1:0] cnt;
      assign ack = req && (cnt == CW'(LAT - 1));
      always_ff @(posedge clk) begin
         if (!rst_n)   cnt <= '0;
         else if (ack) cnt <= '0;
         else if (req) cnt <= cnt + 1'b1;
      end
   end

   // R6
   req_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> req);
endmodule

// File: rtl/mmd_csr_bridge.sv
module mmd_csr_bridge
   import mmd_bridge_pkg::*;
#(
   parameter int CSR_AW     = 12,
   parameter int LAT        = 4,
   parameter int MMD_IMPL_W = 2,
   parameter int REG_IMPL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [CSR_AW-1:0] csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata
);
   logic          busy;
   logic          ack;
   mmd_cmd_t      cmd;
   logic [DW-1:0] data_q;
   logic [DW-1:0] be_rdata;

   mmd_cmd_regs #(.CSR_AW(CSR_AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_we    (csr_we),
      .csr_addr  (csr_addr),
      .csr_wdata (csr_wdata),
      .csr_rdata (csr_rdata),
      .be_ack    (ack),
      .be_rdata  (be_rdata),
      .busy      (busy),
      .cmd       (cmd),
      .data_q    (data_q)
   );

   mmd_regfile_port #(
      .LAT        (LAT),
      .MMD_IMPL_W (MMD_IMPL_W),
      .REG_IMPL_W (REG_IMPL_W)
   ) u_port (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (busy),
      .cmd   (cmd),
      .wdata (data_q),
      .ack   (ack),
      .rdata (be_rdata)
   );

   // R6
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !busy);
endmodule

// File: tb/mmd_csr_bridge_test.sv
`timescale 1ns/1ps
module mmd_csr_bridge_test;
   localparam int LAT = 4;
   localparam logic [11:0] A_CMD  = 12'h720;
   localparam logic [11:0] A_DATA = 12'h724;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   int          total = 0;
   int          bad = 0;
   logic        done = 1'b0;

   always #2.5 clk = ~clk;

   mmd_csr_bridge #(.CSR_AW(12), .LAT(LAT), .MMD_IMPL_W(2), .REG_IMPL_W(3)) uut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic csr_read(input logic [11:0] a, output logic [31:0] d);
      csr_addr = a;
      #0.5;
      d = csr_rdata;
   endtask

   task automatic wait_idle(output int n);
      logic [31:0] v;
      n = 0;
      csr_read(A_CMD, v);
      while (v[31] && n < 1000) begin
         @(negedge clk);
         n++;
         csr_read(A_CMD, v);
      end
   endtask

   task automatic do_write(input int mmd, input int ra, input logic [15:0] val);
      int n;
      csr_write(A_DATA, {16'h0, val});
      csr_write(A_CMD, 32'hC000_0000 | (mmd << 16) | ra);
      wait_idle(n);
   endtask

   task automatic do_read(input int mmd, input int ra, output logic [31:0] val);
      int n;
      csr_write(A_CMD, 32'h8000_0000 | (mmd << 16) | ra);
      wait_idle(n);
      csr_read(A_DATA, val);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      csr_read(A_CMD, v);  chk("R1 cmd after reset", v, 32'h0);
      csr_read(A_DATA, v); chk("R1 data after reset", v, 32'h0);
      do_read(1, 2, v);    chk("R1 regfile after reset", v, 32'h0);
   endtask

   task automatic t_fields();
      logic [31:0] v;
      csr_write(A_CMD, 32'h7FFF_FFFF);
      csr_read(A_CMD, v);  chk("R2 field readback, no launch", v, 32'h401F_FFFF);
      csr_write(A_DATA, 32'hFFFF_ABCD);
      csr_read(A_DATA, v); chk("R3 data upper bits zero", v, 32'h0000_ABCD);
   endtask

   task automatic t_write_read();
      logic [31:0] v;
      int n;
      csr_write(A_DATA, 32'h1234);
      csr_write(A_CMD, 32'hC001_0002);
      wait_idle(n);
      chk("R6 busy cycles", n, LAT);
      csr_read(A_DATA, v); chk("R4 data kept after write", v, 32'h1234);
      do_write(3, 7, 16'hBEEF);
      csr_write(A_DATA, 32'h0);
      do_read(1, 2, v); chk("R5 read mmd1 reg2", v, 32'h1234);
      do_read(3, 7, v); chk("R5 read mmd3 reg7", v, 32'hBEEF);
      csr_write(A_CMD, 32'h8003_0007);
      wait_idle(n);
      chk("R6 busy cycles on read", n, LAT);
   endtask

   task automatic t_cmd_ignore();
      logic [31:0] v;
      int n;
      csr_write(A_DATA, 32'h0);
      csr_write(A_CMD, 32'h8003_0007);
      csr_write(A_CMD, 32'hC002_0005);
      wait_idle(n);
      csr_read(A_CMD, v);  chk("R7 fields unchanged", v, 32'h0003_0007);
      csr_read(A_DATA, v); chk("R7 original read result", v, 32'hBEEF);
      do_read(2, 5, v);    chk("R7 no write launched", v, 32'h0);
   endtask

   task automatic t_data_ignore();
      logic [31:0] v;
      int n;
      csr_write(A_DATA, 32'h5555);
      csr_write(A_CMD, 32'hC000_0001);
      csr_write(A_DATA, 32'h9999);
      wait_idle(n);
      csr_read(A_DATA, v); chk("R8 data word unchanged", v, 32'h5555);
      do_read(0, 1, v);    chk("R8 stored value", v, 32'h5555);
   endtask

   task automatic t_range();
      logic [31:0] v;
      do_write(4, 0, 16'h7777);
      do_read(4, 0, v); chk("R9 unbacked mmd reads 0", v, 32'h0);
      do_read(0, 0, v); chk("R9 no alias onto mmd0 reg0", v, 32'h0);
      do_write(0, 8, 16'h6666);
      do_read(0, 8, v); chk("R9 unbacked addr reads 0", v, 32'h0);
      do_read(0, 0, v); chk("R9 no alias from addr 8", v, 32'h0);
   endtask

   task automatic t_other();
      logic [31:0] v, c;
      csr_read(A_CMD, c);
      csr_write(12'h728, 32'hFFFF_FFFF);
      csr_read(12'h728, v); chk("R10 other offset reads 0", v, 32'h0);
      csr_read(A_CMD, v);   chk("R10 cmd untouched", v, c);
      csr_read(A_DATA, v);  chk("R10 data untouched", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fields();
      t_write_read();
      t_cmd_ignore();
      t_data_ignore();
      t_range();
      t_other();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule